// File: doc/BRIEF.md
# Trigger-Windowed Peak Finder

This block sits behind a sample delay line in a calorimeter readout channel. One digitized word arrives on every clock: a 2-bit range code in bits 11:10 and a 10-bit value in bits 9:0. A Level-1 trigger pulse opens a search window of `WIN_LEN` samples. The default of 62 samples is about 3 µs at a 20.8 MHz sample rate. The delay line is sized so that the shaped pulse should peak near the middle of this window. While the window is open, the block keeps the largest sample seen so far and its position within the window.

When the window closes, the block tests the winning sample against a programmable threshold. If the sample lies above the threshold, the block pushes one event entry into a small first-in-first-out buffer. The entry holds the original 12-bit sample word and a 6-bit peak-time stamp. A bus reader pops entries from the head of the buffer. Two sticky flags report trouble: one for triggers that arrived while a window was already open, and one for entries lost because the buffer was full.

Top module: `trig_peak_finder`

## Requirements
- R1: After reset the buffer reports empty and not full, and both sticky flags (`trig_miss`, `buf_overflow`) read 0.
- R2: A trigger seen while no window is open starts a window of `WIN_LEN` samples. The sample presented in the trigger cycle is index 0. A qualifying entry is visible at `rd_data` two clock edges after the last window sample is presented.
- R3: Samples are ranked by magnitude, defined as value (bits 9:0) multiplied by 8 to the power of the range code (bits 11:10). The stored word is the original 12-bit sample.
- R4: An entry is `{ptime[5:0], word[11:0]}`, with `ptime` in bits 17:12. `ptime` is the window index of the largest sample, counted from 0 and saturating at 63.
- R5: When two samples in a window share the largest magnitude, the earlier one is kept, even if their words differ.
- R6: An entry is written only when the peak magnitude is strictly greater than `thresh`.
- R7: A trigger that arrives while a window is open does not restart or alter that window, and it sets `trig_miss`, which holds until reset.
- R8: If the buffer is full and not being read when a qualifying window closes, the entry is discarded. `buf_overflow` is set and held until reset, and the stored entries are untouched.
- R9: If the buffer is full and the host pops in the same cycle that a qualifying window closes, the new entry is written and `buf_overflow` does not change.
- R10: A trigger in the cycle right after a window's last sample starts a new window without setting `trig_miss`, and both windows produce their entries.
- R11: Entries leave in the order they were written. A read while empty has no effect, and `buf_empty` and `buf_full` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_in | input | 12 | Delayed sample word: range code in 11:10, value in 9:0 |
| l1_trig | input | 1 | Level-1 trigger pulse |
| thresh | input | 19 | Magnitude threshold |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 18 | Head entry `{ptime, word}` |
| buf_empty | output | 1 | Buffer holds no entry |
| buf_full | output | 1 | Buffer holds `FIFO_DEPTH` entries |
| trig_miss | output | 1 | Sticky: a trigger was ignored |
| buf_overflow | output | 1 | Sticky: an entry was lost |

## Verification
A window commit can land in the same cycle as a host pop on a full buffer. It can also land in the same cycle as a fresh trigger. The bench fills the buffer to depth and then schedules a pop exactly on the commit edge. It judges the result by a clear overflow flag and by popping back the shifted sequence of entries in order. For the trigger collision, it drives a continuous stream with the second trigger placed on the sample right after the first window's last one. It then expects two correctly timed entries and no miss flag.

// File: rtl/pf_pkg.sv
// Shared widths, entry layout and magnitude mapping for the peak finder.
// Assumes a 2-bit range code above a 10-bit value; each range step is x8.
package pf_pkg;
    localparam int RANGE_W    = 2;
    localparam int VAL_W      = 10;
    localparam int WORD_W     = RANGE_W + VAL_W;
    localparam int SHIFT_STEP = 3;
    localparam int MAG_W      = VAL_W + SHIFT_STEP * ((1 << RANGE_W) - 1);
    localparam int TIME_W     = 6;
    localparam int ENTRY_W    = TIME_W + WORD_W;

    typedef struct packed {
        logic [TIME_W-1:0] ptime;
        logic [WORD_W-1:0] word;
    } pf_entry_t;

    // Map a range-coded word onto one common magnitude scale.
    function automatic logic [MAG_W-1:0] pf_linearize(input logic [WORD_W-1:0] w);
        logic [MAG_W-1:0] m;
        m = MAG_W'(w[VAL_W-1:0]);
        return m << (SHIFT_STEP * int'(w[WORD_W-1:VAL_W]));
    endfunction
endpackage

// File: rtl/pf_window.sv
// Trigger-aligned search window: tracks the largest sample and its index.
// Assumes one sample per clock and WIN_LEN >= 2. The trigger-cycle sample
// is index 0. done pulses for one cycle after the last sample, while the
// pk_* outputs hold the result of the window that just closed.
module pf_window
    import pf_pkg::*;
#(
    parameter int WIN_LEN = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] smp,
    input  logic              trig,
    output logic              win_open,
    output logic              done,
    output logic [WORD_W-1:0] pk_word,
    output logic [MAG_W-1:0]  pk_mag,
    output logic [TIME_W-1:0] pk_time,
    output logic              miss
);
    localparam int CNT_W = $clog2(WIN_LEN + 1);
    localparam int TMAX  = (1 << TIME_W) - 1;

    logic [CNT_W-1:0]  idx;
    logic [MAG_W-1:0]  smp_mag;
    logic [TIME_W-1:0] idx_sat;

    // Magnitude of the incoming sample and the saturated index stamp.
    always_comb begin
        smp_mag = pf_linearize(smp);
        if (int'(idx) > TMAX) idx_sat = TIME_W'(TMAX);
        else                  idx_sat = TIME_W'(idx);
    end

    // Window sequencing, running maximum and miss flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open <= 1'b0;
            done     <= 1'b0;
            idx      <= '0;
            pk_word  <= '0;
            pk_mag   <= '0;
            pk_time  <= '0;
            miss     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!win_open) begin
                if (trig) begin
                    win_open <= 1'b1;
                    idx      <= CNT_W'(1);
                    pk_word  <= smp;
                    pk_mag   <= smp_mag;
                    pk_time  <= '0;
                end
            end else begin
                if (trig) miss <= 1'b1;
                if (smp_mag > pk_mag) begin
                    pk_word <= smp;
                    pk_mag  <= smp_mag;
                    pk_time <= idx_sat;
                end
                idx <= idx + 1'b1;
                if (idx == CNT_W'(WIN_LEN - 1)) begin
                    win_open <= 1'b0;
                    done     <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pf_event_fifo.sv
// Show-ahead event buffer. Assumes DEPTH is a power of two.
// A write while full succeeds only if a read happens in the same cycle.
// wr_drop flags a write request that was refused.
module pf_event_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full,
    output logic         wr_drop
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic         do_rd, do_wr;

    // Status and accepted-operation decode.
    always_comb begin
        empty   = (wp == rp);
        full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
        do_rd   = rd_en && !empty;
        do_wr   = wr_en && (!full || do_rd);
        wr_drop = wr_en && !do_wr;
        rd_data = mem[rp[AW-1:0]];
    end

    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp[AW-1:0]] <= wr_data;
    end
endmodule

// File: rtl/trig_peak_finder.sv
// Top: windowed peak search, threshold qualification and event buffering.
// Assumes a continuous sample stream already delayed to line up with the
// trigger. Both sticky flags clear only on reset.
module trig_peak_finder
    import pf_pkg::*;
#(
    parameter int WIN_LEN    = 62,
    parameter int FIFO_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  smp_in,
    input  logic               l1_trig,
    input  logic [MAG_W-1:0]   thresh,
    input  logic               rd_en,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               buf_empty,
    output logic               buf_full,
    output logic               trig_miss,
    output logic               buf_overflow
);
    logic              win_open, win_done, cm_req, wr_drop;
    logic [WORD_W-1:0] pk_word;
    logic [MAG_W-1:0]  pk_mag;
    logic [TIME_W-1:0] pk_time;
    pf_entry_t         entry;

    pf_window #(.WIN_LEN(WIN_LEN)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp      (smp_in),
        .trig     (l1_trig),
        .win_open (win_open),
        .done     (win_done),
        .pk_word  (pk_word),
        .pk_mag   (pk_mag),
        .pk_time  (pk_time),
        .miss     (trig_miss)
    );

    // Qualify the closed window against the threshold and pack the entry.
    always_comb begin
        cm_req      = win_done && (pk_mag > thresh);
        entry.ptime = pk_time;
        entry.word  = pk_word;
    end

    pf_event_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cm_req),
        .wr_data (entry),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .empty   (buf_empty),
        .full    (buf_full),
        .wr_drop (wr_drop)
    );

    // Sticky record of entries lost to a full buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)       buf_overflow <= 1'b0;
        else if (wr_drop) buf_overflow <= 1'b1;
    end
endmodule

// File: rtl/pf_checker.sv
// Temporal checks on the peak finder, attached by bind.
module pf_checker
    import pf_pkg::*;
#(
    parameter int WIN_LEN = 62
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l1_trig,
    input logic               win_open,
    input logic               cm_req,
    input logic               rd_en,
    input logic               buf_empty,
    input logic               buf_full,
    input logic               trig_miss,
    input logic               buf_overflow,
    input logic [ENTRY_W-1:0] rd_data
);
    // R7
    miss_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_trig && win_open) |=> trig_miss);
    // R7
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_miss |=> trig_miss);
    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_req && buf_full && !rd_en) |=> buf_overflow);
    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_overflow |=> buf_overflow);
    // R9
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_req && buf_full && rd_en) |=> (buf_full && $stable(buf_overflow)));
    // R11
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_empty && buf_full));
    // R4
    time_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_empty |-> (int'(rd_data[ENTRY_W-1:WORD_W]) < WIN_LEN));
endmodule

bind trig_peak_finder pf_checker #(.WIN_LEN(WIN_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .l1_trig      (l1_trig),
    .win_open     (win_open),
    .cm_req       (cm_req),
    .rd_en        (rd_en),
    .buf_empty    (buf_empty),
    .buf_full     (buf_full),
    .trig_miss    (trig_miss),
    .buf_overflow (buf_overflow),
    .rd_data      (rd_data)
);

// File: tb/trig_peak_finder_bench.sv
module trig_peak_finder_bench;
    localparam int WIN   = 62;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] smp_in = '0;
    logic        l1_trig = 1'b0;
    logic [18:0] thresh = '0;
    logic        rd_en = 1'b0;
    logic [17:0] rd_data;
    logic        buf_empty, buf_full, trig_miss, buf_overflow;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [11:0] strm  [2*WIN];
    bit          tmask [2*WIN];

    always #2 clk = ~clk;

    trig_peak_finder #(.WIN_LEN(WIN), .FIFO_DEPTH(DEPTH)) u_trig_peak_finder (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .l1_trig(l1_trig),
        .thresh(thresh), .rd_en(rd_en), .rd_data(rd_data),
        .buf_empty(buf_empty), .buf_full(buf_full),
        .trig_miss(trig_miss), .buf_overflow(buf_overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Magnitude per R3: value times 8 to the power of the range code.
    function automatic int lin(input logic [11:0] w);
        return int'(w[9:0]) * (8 ** int'(w[11:10]));
    endfunction

    // Expected peak of the window starting at offset st (earliest max wins).
    task automatic model(input int st, output int t, output logic [11:0] w);
        int best = -1;
        t = 0; w = '0;
        for (int j = 0; j < WIN; j++) begin
            if (lin(strm[st+j]) > best) begin
                best = lin(strm[st+j]); t = j; w = strm[st+j];
            end
        end
    endtask

    task automatic clear_stream();
        for (int i = 0; i < 2*WIN; i++) begin
            strm[i] = '0; tmask[i] = 1'b0;
        end
        tmask[0] = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive len samples, then pop on the commit edge if pop is set.
    task automatic run_stream(input int len, input bit pop);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            smp_in = strm[i]; l1_trig = tmask[i];
        end
        @(negedge clk);
        smp_in = '0; l1_trig = 1'b0; rd_en = pop;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_pop(input string req, input int t, input logic [11:0] w);
        chk({req, " nonempty"}, int'(buf_empty), 0);
        chk({req, " ptime"}, int'(rd_data[17:12]), t);
        chk({req, " word"}, int'(rd_data[11:0]), int'(w));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int t; logic [11:0] w;
        do_reset();
        // R1 reset state
        chk("R1 empty", int'(buf_empty), 1);
        chk("R1 full", int'(buf_full), 0);
        chk("R1 miss", int'(trig_miss), 0);
        chk("R1 overflow", int'(buf_overflow), 0);

        // R2 R4: sweep peak over every window position, mixed-range background
        thresh = '0;
        for (int p = 0; p < WIN; p++) begin
            clear_stream();
            for (int j = 0; j < WIN; j++) strm[j] = {2'(j % 3), 10'((j * 7) % 50)};
            strm[p] = {2'b11, 10'(100 + p)};
            model(0, t, w);
            chk("R4 model position", t, p);
            run_stream(WIN, 1'b0);
            expect_pop("R2 R4 sweep", t, w);
            chk("R2 drained", int'(buf_empty), 1);
        end

        // R3 cross-range ranking
        clear_stream();
        strm[3] = {2'b00, 10'd1000};
        strm[7] = {2'b01, 10'd100};
        strm[9] = {2'b10, 10'd20};
        run_stream(WIN, 1'b0);
        expect_pop("R3 range2 wins", 9, {2'b10, 10'd20});
        clear_stream();
        strm[3] = {2'b00, 10'd1000};
        strm[7] = {2'b01, 10'd100};
        run_stream(WIN, 1'b0);
        expect_pop("R3 raw value wins", 3, {2'b00, 10'd1000});

        // R5 ties keep the earlier sample
        clear_stream();
        strm[5]  = {2'b01, 10'd1};
        strm[30] = {2'b00, 10'd8};
        run_stream(WIN, 1'b0);
        expect_pop("R5 tie mixed words", 5, {2'b01, 10'd1});
        clear_stream();
        strm[12] = {2'b10, 10'd77};
        strm[40] = {2'b10, 10'd77};
        run_stream(WIN, 1'b0);
        expect_pop("R5 tie same word", 12, {2'b10, 10'd77});

        // R6 strict threshold
        clear_stream();
        strm[20] = {2'b00, 10'd500};
        thresh = 19'd500;
        run_stream(WIN, 1'b0);
        chk("R6 equal suppressed", int'(buf_empty), 1);
        thresh = 19'd499;
        run_stream(WIN, 1'b0);
        expect_pop("R6 above stored", 20, {2'b00, 10'd500});
        thresh = '0;

        // R10 back-to-back windows
        clear_stream();
        tmask[WIN] = 1'b1;
        strm[20] = {2'b01, 10'd300};
        strm[WIN + 33] = {2'b10, 10'd15};
        run_stream(2 * WIN, 1'b0);
        chk("R10 no miss", int'(trig_miss), 0);
        expect_pop("R10 first", 20, {2'b01, 10'd300});
        expect_pop("R10 second", 33, {2'b10, 10'd15});

        // R7 trigger inside open window ignored
        clear_stream();
        tmask[10] = 1'b1;
        strm[40] = {2'b00, 10'd222};
        run_stream(WIN, 1'b0);
        chk("R7 miss set", int'(trig_miss), 1);
        expect_pop("R7 window not restarted", 40, {2'b00, 10'd222});

        // R8 R11 overflow and ordering
        for (int k = 0; k < DEPTH; k++) begin
            clear_stream();
            strm[10 + k] = {2'b00, 10'(50 + k)};
            run_stream(WIN, 1'b0);
        end
        chk("R8 full", int'(buf_full), 1);
        chk("R8 no overflow yet", int'(buf_overflow), 0);
        clear_stream();
        strm[50] = {2'b11, 10'd999};
        run_stream(WIN, 1'b0);
        chk("R8 overflow set", int'(buf_overflow), 1);
        for (int k = 0; k < DEPTH; k++)
            expect_pop("R8 R11 order kept", 10 + k, {2'b00, 10'(50 + k)});
        chk("R11 empty", int'(buf_empty), 1);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R11 read on empty", int'(buf_empty), 1);
        chk("R11 not full", int'(buf_full), 0);

        // R9 commit with simultaneous pop on a full buffer
        do_reset();
        for (int k = 0; k < DEPTH; k++) begin
            clear_stream();
            strm[20 + k] = {2'b01, 10'(10 + k)};
            run_stream(WIN, 1'b0);
        end
        clear_stream();
        strm[44] = {2'b01, 10'd99};
        run_stream(WIN, 1'b1);
        chk("R9 overflow clear", int'(buf_overflow), 0);
        chk("R9 still full", int'(buf_full), 1);
        for (int k = 1; k < DEPTH; k++)
            expect_pop("R9 shifted order", 20 + k, {2'b01, 10'(10 + k)});
        expect_pop("R9 new entry", 44, {2'b01, 10'd99});
        chk("R9 drained", int'(buf_empty), 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule